// File: doc/BRIEF.md
# Two-Digit Decimal Counter with Commanded Stages

This block counts in binary-coded decimal across two digits, a ones digit and a tens digit. Each digit is its own mod-10 stage with a 4-bit register. The stages share one clock and one active-low reset. A 2-bit command selects one of four actions: keep the value, step up, take a parallel value, or clear synchronously. The ones stage obeys the external command directly. The tens stage receives a command built by glue logic. That logic passes load and clear straight through. It turns a step request into a real step only when the ones digit is about to wrap.

Each stage gives two roll indications. The first is combinational and says "this digit is at 9 and is being told to step". The second is registered and says "the last step of this digit wrapped it". The combinational roll of the tens stage is the carry-out. A further pair of digits can use it as its step qualifier. Display decoding is left to the surrounding logic.

Top module: `dual_decade_counter`

## Requirements
- R1: Digit values and wrap flags change only on a rising clock edge; between edges, including at the falling edge, all of them keep their values.
- R2: While rst_n is 0 at a rising edge, both digits and both wrap flags become 0, whatever ctrl_i and load_i carry.
- R3: ctrl_i = 2'b00 (keep) leaves both digits and both wrap flags unchanged across the edge.
- R4: ctrl_i = 2'b10 (take) loads ones_o from load_i[3:0] and tens_o from load_i[7:4] on the edge, including values above 9.
- R5: ctrl_i = 2'b11 (clear) sets both digits to 0 on the edge and leaves both wrap flags unchanged.
- R6: ctrl_i = 2'b01 (step) advances the ones digit 0,1,…,9,0; starting from 00, repeated steps visit every value 00 to 99 in order and then return to 00.
- R7: wrapped_o[0] (ones) and wrapped_o[1] (tens) are each set on an edge where that digit steps from 9 to 0, and cleared on an edge where that digit steps without wrapping.
- R8: carry_o is combinational and is 1 exactly when ones_o = 9, tens_o = 9 and ctrl_i = 2'b01.
- R9: During step commands, the tens digit changes only on an edge where the ones digit wraps from 9 to 0; on other step edges tens_o and wrapped_o[1] are unchanged.
- R10: A digit holding a value above 9 that is told to step becomes 0 and does not wrap: its wrap flag is cleared and the digit above it does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| ctrl_i | input | 2 | Command: 00 keep, 01 step, 10 take, 11 clear |
| load_i | input | 8 | Parallel value: tens in [7:4], ones in [3:0] |
| ones_o | output | 4 | Ones digit value |
| tens_o | output | 4 | Tens digit value |
| wrapped_o | output | 2 | Registered wrap flags: [0] ones, [1] tens |
| carry_o | output | 1 | Combinational carry for a further stage |

## Verification
The digits and the wrap flags react to a command on the next rising edge after it is applied. The bench drives the command at the falling edge and compares them with its model 2 ns after that rising edge. It compares them again at the following falling edge, before it drives anything new, so a change between edges would show. carry_o is due in the same cycle as the command. It is sampled 1 ns after the inputs change and compared with the model's value for the present state. The model is kept in plain integers and updated once per rising edge.

// File: rtl/dual_decade_counter_pkg.sv
package dual_decade_counter_pkg;

  typedef enum logic [1:0] {
    CMD_KEEP  = 2'b00,
    CMD_STEP  = 2'b01,
    CMD_TAKE  = 2'b10,
    CMD_CLEAR = 2'b11
  } digit_cmd_t;

  // Command seen by a higher stage, given the external command and the
  // qualified roll of the stage below it.
  function automatic digit_cmd_t upper_cmd(input digit_cmd_t ext, input logic below_rolls);
    digit_cmd_t res;
    unique case (ext)
      CMD_STEP:  res = below_rolls ? CMD_STEP : CMD_KEEP;
      CMD_TAKE:  res = CMD_TAKE;
      CMD_CLEAR: res = CMD_CLEAR;
      default:   res = CMD_KEEP;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/decade_stage.sv
module decade_stage
  import dual_decade_counter_pkg::*;
#(
  parameter int DW    = 4,
  parameter int RADIX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  digit_cmd_t    cmd_i,
  input  logic [DW-1:0] par_i,
  output logic [DW-1:0] val_o,
  output logic          roll_now_o,
  output logic          roll_reg_o
);

  localparam logic [DW-1:0] TOP_VAL = DW'(RADIX - 1);

  logic [DW-1:0] val_q;
  logic          roll_q;

  // Next value when stepping: wrap at the top, force 0 when out of range.
  function automatic logic [DW-1:0] step_val(input logic [DW-1:0] cur);
    if (cur >= TOP_VAL) return '0;
    return cur + 1'b1;
  endfunction

  function automatic logic is_top(input logic [DW-1:0] cur);
    return cur == TOP_VAL;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      unique case (cmd_i)
        CMD_STEP: begin
          val_q  <= step_val(val_q);
          roll_q <= is_top(val_q);
        end
        CMD_TAKE:  val_q <= par_i;
        CMD_CLEAR: val_q <= '0;
        default: ;
      endcase
    end
  end

  assign val_o      = val_q;
  assign roll_reg_o = roll_q;
  assign roll_now_o = is_top(val_q) && (cmd_i == CMD_STEP);

endmodule

// File: rtl/stage_glue.sv
module stage_glue
  import dual_decade_counter_pkg::*;
(
  input  digit_cmd_t ext_cmd_i,
  input  logic       below_roll_i,
  output digit_cmd_t cmd_o
);

  always_comb cmd_o = upper_cmd(ext_cmd_i, below_roll_i);

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dual_decade_counter_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ctrl_i,
  input  logic [2*DIGIT_W-1:0] load_i,
  output logic [DIGIT_W-1:0]   ones_o,
  output logic [DIGIT_W-1:0]   tens_o,
  output logic [1:0]           wrapped_o,
  output logic                 carry_o
);

  localparam int NDIG = 2;

  digit_cmd_t         ext_cmd;
  digit_cmd_t         stage_cmd [NDIG];
  logic [DIGIT_W-1:0] stage_val [NDIG];
  logic [NDIG-1:0]    roll_now;
  logic [NDIG-1:0]    roll_reg;

  // Named event wires for the checker.
  logic [1:0] tens_cmd;
  logic       ones_roll_now;

  assign ext_cmd = digit_cmd_t'(ctrl_i);

  for (genvar k = 0; k < NDIG; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_cmd[k] = ext_cmd;
    end else begin : g_chain
      stage_glue u_glue (
        .ext_cmd_i    (ext_cmd),
        .below_roll_i (roll_now[k-1]),
        .cmd_o        (stage_cmd[k])
      );
    end

    decade_stage #(
      .DW    (DIGIT_W),
      .RADIX (RADIX)
    ) u_digit (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (stage_cmd[k]),
      .par_i      (load_i[k*DIGIT_W +: DIGIT_W]),
      .val_o      (stage_val[k]),
      .roll_now_o (roll_now[k]),
      .roll_reg_o (roll_reg[k])
    );
  end

  assign ones_o        = stage_val[0];
  assign tens_o        = stage_val[1];
  assign wrapped_o     = roll_reg;
  assign carry_o       = roll_now[NDIG-1];
  assign tens_cmd      = stage_cmd[1];
  assign ones_roll_now = roll_now[0];

endmodule

// File: rtl/dual_decade_counter_chk.sv
module dual_decade_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctrl_i,
  input logic [7:0] load_i,
  input logic [3:0] ones_o,
  input logic [3:0] tens_o,
  input logic [1:0] wrapped_o,
  input logic       carry_o,
  input logic [1:0] tens_cmd,
  input logic       ones_roll_now
);

  AST_RESET_ZEROES: assert property (@(posedge clk) !rst_n |=> (ones_o == 4'd0 && tens_o == 4'd0 && wrapped_o == 2'b00)); // R2

  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == 2'b00) |=> ($stable(ones_o) && $stable(tens_o) && $stable(wrapped_o))); // R3

  AST_TAKE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == 2'b10) |=> (ones_o == $past(load_i[3:0]) && tens_o == $past(load_i[7:4]))); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == 2'b11) |=> (ones_o == 4'd0 && tens_o == 4'd0 && $stable(wrapped_o))); // R5

  AST_ONES_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == 2'b01 && ones_o == 4'd9) |=> (ones_o == 4'd0 && wrapped_o[0])); // R7

  AST_CARRY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o == (ones_o == 4'd9 && tens_o == 4'd9 && ctrl_i == 2'b01)); // R8

  AST_TENS_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_cmd == 2'b01) |-> (ones_o == 4'd9 && ctrl_i == 2'b01)); // R9

  AST_TENS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == 2'b01 && !ones_roll_now) |=> ($stable(tens_o) && $stable(wrapped_o[1]))); // R9

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == 2'b01 && ones_o > 4'd9) |=> (ones_o == 4'd0 && !wrapped_o[0] && $stable(tens_o))); // R10

endmodule

bind dual_decade_counter dual_decade_counter_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_i        (ctrl_i),
  .load_i        (load_i),
  .ones_o        (ones_o),
  .tens_o        (tens_o),
  .wrapped_o     (wrapped_o),
  .carry_o       (carry_o),
  .tens_cmd      (tens_cmd),
  .ones_roll_now (ones_roll_now)
);

// File: tb/test_dual_decade_counter.sv
`timescale 1ns/1ps
module test_dual_decade_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctrl = 2'b00;
  logic [7:0] load = 8'h00;
  logic [3:0] ones_o, tens_o;
  logic [1:0] wrapped_o;
  logic       carry_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state as plain integers.
  int m_ones = 0, m_tens = 0, m_w0 = 0, m_w1 = 0;

  always #2.5 clk = ~clk;

  dual_decade_counter i_dual_decade_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (ctrl),
    .load_i    (load),
    .ones_o    (ones_o),
    .tens_o    (tens_o),
    .wrapped_o (wrapped_o),
    .carry_o   (carry_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Decimal value shown by the two digits, compared against the model.
  task automatic compare_state(input string req);
    check({req, " ones"}, int'(ones_o), m_ones);
    check({req, " tens"}, int'(tens_o), m_tens);
    check({req, " wrap0"}, int'(wrapped_o[0]), m_w0);
    check({req, " wrap1"}, int'(wrapped_o[1]), m_w1);
  endtask

  task automatic model_edge(input bit r, input int c, input int d);
    if (!r) begin
      m_ones = 0; m_tens = 0; m_w0 = 0; m_w1 = 0;
    end else if (c == 1) begin
      if (m_ones == 9) begin
        m_ones = 0; m_w0 = 1;
        if (m_tens == 9) begin m_tens = 0; m_w1 = 1; end
        else if (m_tens > 9) begin m_tens = 0; m_w1 = 0; end
        else begin m_tens = m_tens + 1; m_w1 = 0; end
      end else if (m_ones > 9) begin
        m_ones = 0; m_w0 = 0;
      end else begin
        m_ones = m_ones + 1; m_w0 = 0;
      end
    end else if (c == 2) begin
      m_ones = d % 16; m_tens = d / 16;
    end else if (c == 3) begin
      m_ones = 0; m_tens = 0;
    end
  endtask

  // One clock cycle: drive at the falling edge, check carry, then state.
  task automatic cyc(input bit r, input int c, input int d, input string req);
    @(negedge clk);
    compare_state("R1 falling-edge hold");
    rst_n = r; ctrl = 2'(c); load = 8'(d);
    #1;
    check("R8 carry", int'(carry_o), (m_ones == 9 && m_tens == 9 && c == 1) ? 1 : 0);
    @(posedge clk);
    model_edge(r, c, d);
    #2;
    compare_state(req);
  endtask

  initial begin
    repeat (3) cyc(1'b0, 1, 8'h55, "R2 reset");
    // Full sweep 00 -> 99 -> 00 and a bit beyond.
    for (int i = 0; i < 105; i++) cyc(1'b1, 1, 0, "R6 R7 R9 sweep");
    repeat (4) cyc(1'b1, 0, 8'h77, "R3 keep");
    cyc(1'b1, 2, 8'h37, "R4 take 37");
    cyc(1'b1, 0, 0, "R3 keep after take");
    cyc(1'b1, 2, 8'h98, "R4 take 98");
    repeat (3) cyc(1'b1, 1, 0, "R6 R8 step to 00");
    cyc(1'b1, 2, 8'h42, "R4 take 42");
    cyc(1'b1, 3, 8'h99, "R5 clear");
    cyc(1'b1, 1, 0, "R5 step after clear");
    cyc(1'b1, 2, 8'h5C, "R4 take 5C");
    cyc(1'b1, 1, 0, "R10 ones out of range");
    cyc(1'b1, 2, 8'hB9, "R4 take B9");
    cyc(1'b1, 1, 0, "R10 tens out of range");
    cyc(1'b1, 2, 8'h97, "R4 take 97");
    repeat (4) cyc(1'b1, 1, 0, "R7 R9 step");
    cyc(1'b0, 1, 0, "R2 reset mid count");
    repeat (12) cyc(1'b1, 1, 0, "R6 restart after reset");
    @(negedge clk);
    compare_state("R1 final");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule